// File: doc/BRIEF.md
# Berger-predicting checked ALU

This block is an n-bit integer ALU that watches itself while it works. It computes its result and also produces the Berger check code of that result, defined as the count of zero bits. The code comes out of two separate paths. One path predicts the code from the operands' own check codes. For add and subtract it also uses the internal carry or borrow vector. The other path counts the zeros of the result that the datapath actually produced. The two values are compared on every operation. A mismatch raises a fault flag in the same registered cycle as the result, and operation is never stopped.

The caller supplies both operands together with their zero-count codes, a carry or borrow input and a six-bit opcode. One cycle later the block returns the result, the predicted code and the flag. A small fault-injection control input lets an in-field self-test provoke the failures the checker is meant to catch. It can hold the adder carry stuck at one, invert a result bit, invert a bit of the carry vector seen by the predictor, or corrupt the opcode on the execution path only.

Top module: `berger_checked_alu`

## Requirements
- R1: Opcode 6'h01 (ADD) returns (A + B + cin) mod 2^n one clock edge after the inputs are sampled.
- R2: Opcode 6'h02 (SUB) returns (A − B − cin) mod 2^n, with cin acting as borrow-in.
- R3: Opcodes 6'h03 OR, 6'h04 AND, 6'h05 XNOR, 6'h06 XOR and 6'h07 NOT (of A) return the bitwise result.
- R4: With injection control 4'b0000 and operand codes equal to the zero counts of A and B, the code output equals the number of zero bits in the result.
- R5: With injection control 4'b0000 and valid operand codes, the fault flag stays 0 for every opcode and operand pattern.
- R6: Injection bit 0 holds the adder's carry-in at 1 while the predictor still sees the cin port. ADD of 1 + 2 with cin = 0 then returns 4 with the fault flag at 1. With cin = 1 the result is the same and the flag stays 0.
- R7: Injection bit 1 inverts result bit 0 after the datapath. The fault flag is then 1 for any opcode, and the code output is still the zero count of the uninverted result.
- R8: Injection bit 2 inverts bit 0 of the carry/borrow vector fed to the predictor. It raises the flag on ADD and SUB. On the logic opcodes it has no effect: the result is correct and the flag stays 0.
- R9: Injection bit 3 XORs the execution-path opcode with 6'b000110 while the predictor keeps the issued opcode. OR of 4 and 5 then returns 32'hFFFFFFFE, the XNOR result, with the flag at 1.
- R10: Any opcode outside 6'h01..6'h07 returns result 0, code n and flag 0.
- R11: While reset is active the outputs are result 0, code n and flag 0.
- R12: Outputs are registered. Between clock edges they hold the value produced by the previous operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | WIDTH | Operand A |
| op_b | input | WIDTH | Operand B |
| code_a | input | CODE_W | Zero count of op_a |
| code_b | input | CODE_W | Zero count of op_b |
| carry_in | input | 1 | Carry-in for ADD, borrow-in for SUB |
| opcode | input | 6 | Operation select |
| inj_ctl | input | 4 | Fault injection: [0] carry stuck at 1, [1] result bit flip, [2] carry-vector flip, [3] opcode corruption |
| result | output | WIDTH | Registered ALU result |
| result_code | output | CODE_W | Registered predicted zero count of the result |
| fault_flag | output | 1 | Registered mismatch between predicted and actual code |

## Verification
Every opcode is driven with random operands and with extreme patterns: all zeros, all ones, a single one and a single zero. These show whether the carry and borrow terms of the prediction hold when every bit position carries, and when none does. Each of the four injection controls is applied on its own. This separates faults the checker must see (a wrong carry-in, a corrupted result bit, a corrupted carry vector on arithmetic, a corrupted opcode) from a flipped carry vector on logic operations, which must pass silently. Undefined opcodes and the reset state confirm that the prediction and the actual count agree on an all-zero result.

// File: rtl/berger_alu_pkg.sv
package berger_alu_pkg;

  typedef enum logic [5:0] {
    OP_ADD  = 6'h01,
    OP_SUB  = 6'h02,
    OP_OR   = 6'h03,
    OP_AND  = 6'h04,
    OP_XNOR = 6'h05,
    OP_XOR  = 6'h06,
    OP_NOT  = 6'h07
  } alu_op_e;

  // bit positions of the fault-injection control
  localparam int INJ_CIN_STUCK = 0;
  localparam int INJ_RES_FLIP  = 1;
  localparam int INJ_VEC_FLIP  = 2;
  localparam int INJ_OPC_FLIP  = 3;
  localparam int INJ_W         = 4;

  // opcode bits corrupted by the opcode injection
  localparam logic [5:0] OPC_FLIP_MASK = 6'b000110;

endpackage

// File: rtl/balu_zero_count.sv
module balu_zero_count #(
  parameter int W  = 32,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] zeros
);

  always_comb begin
    zeros = '0;
    for (int i = 0; i < W; i++) begin
      zeros = zeros + {{(CW-1){1'b0}}, ~vec[i]};
    end
  end

endmodule

// File: rtl/balu_datapath.sv
module balu_datapath
  import berger_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  input  logic [5:0]       op,
  output logic [WIDTH-1:0] res,
  output logic [WIDTH-1:0] carry_vec
);

  logic [WIDTH-1:0] cin_w;
  logic [WIDTH-1:0] carry_into;

  assign cin_w = {{(WIDTH-1){1'b0}}, cin};

  // carry_vec[i] is the carry (or borrow) leaving bit i; the top bit is cout
  always_comb begin
    res        = '0;
    carry_into = '0;
    carry_vec  = '0;
    case (op)
      OP_ADD: begin
        res        = a + b + cin_w;
        carry_into = a ^ b ^ res;
        carry_vec  = (a & b) | ((a ^ b) & carry_into);
      end
      OP_SUB: begin
        res        = a - b - cin_w;
        carry_into = a ^ b ^ res;
        carry_vec  = (~a & b) | (~(a ^ b) & carry_into);
      end
      OP_OR:   res = a | b;
      OP_AND:  res = a & b;
      OP_XNOR: res = ~(a ^ b);
      OP_XOR:  res = a ^ b;
      OP_NOT:  res = ~a;
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/balu_predictor.sv
module balu_predictor
  import berger_alu_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int CW = $clog2(WIDTH + 1),
  localparam int PW = CW + 3
) (
  input  logic [5:0]           op,
  input  logic [WIDTH-1:0]     a,
  input  logic [WIDTH-1:0]     b,
  input  logic [CW-1:0]        code_a,
  input  logic [CW-1:0]        code_b,
  input  logic                 cin,
  input  logic [WIDTH-1:0]     carry_vec,
  output logic signed [PW-1:0] pred
);

  localparam logic signed [PW-1:0] N_S = PW'(WIDTH);

  function automatic logic signed [PW-1:0] widen(input logic [CW-1:0] v);
    return $signed({{(PW-CW){1'b0}}, v});
  endfunction

  function automatic logic signed [PW-1:0] widen_bit(input logic v);
    return $signed({{(PW-1){1'b0}}, v});
  endfunction

  logic [CW-1:0] zc_and, zc_or, zc_vec;
  logic [WIDTH-1:0] a_and_b, a_or_b;

  assign a_and_b = a & b;
  assign a_or_b  = a | b;

  // side terms of the prediction, counted on their own vectors
  balu_zero_count #(.W(WIDTH)) u_zc_and (.vec(a_and_b),   .zeros(zc_and));
  balu_zero_count #(.W(WIDTH)) u_zc_or  (.vec(a_or_b),    .zeros(zc_or));
  balu_zero_count #(.W(WIDTH)) u_zc_vec (.vec(carry_vec), .zeros(zc_vec));

  logic signed [PW-1:0] sa, sb, s_and, s_or, s_vec, s_cin, s_cout, s_xor;

  always_comb begin
    sa     = widen(code_a);
    sb     = widen(code_b);
    s_and  = widen(zc_and);
    s_or   = widen(zc_or);
    s_vec  = widen(zc_vec);
    s_cin  = widen_bit(cin);
    s_cout = widen_bit(carry_vec[WIDTH-1]);
    s_xor  = sa + sb - s_and - s_and + N_S;
    case (op)
      OP_ADD:  pred = sa + sb - s_cin - s_vec + s_cout;
      OP_SUB:  pred = sa - sb + s_vec + s_cin - s_cout;
      OP_AND:  pred = sa + sb - s_or;
      OP_OR:   pred = sa + sb - s_and;
      OP_XOR:  pred = s_xor;
      OP_XNOR: pred = N_S - s_xor;
      OP_NOT:  pred = N_S - sa;
      default: pred = N_S;
    endcase
  end

endmodule

// File: rtl/berger_checked_alu.sv
module berger_checked_alu
  import berger_alu_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int CODE_W = $clog2(WIDTH + 1),
  localparam int PRED_W = CODE_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIDTH-1:0]  op_a,
  input  logic [WIDTH-1:0]  op_b,
  input  logic [CODE_W-1:0] code_a,
  input  logic [CODE_W-1:0] code_b,
  input  logic              carry_in,
  input  logic [5:0]        opcode,
  input  logic [INJ_W-1:0]  inj_ctl,
  output logic [WIDTH-1:0]  result,
  output logic [CODE_W-1:0] result_code,
  output logic              fault_flag
);

  localparam logic signed [PRED_W-1:0] N_S = PRED_W'(WIDTH);

  // named internal events
  logic [5:0]               op_exec;
  logic                     cin_exec;
  logic [WIDTH-1:0]         res_raw, res_final;
  logic [WIDTH-1:0]         vec_raw, vec_pred;
  logic [CODE_W-1:0]        actual_code;
  logic signed [PRED_W-1:0] pred_code;
  logic                     pred_in_range;
  logic                     mismatch;

  assign op_exec   = inj_ctl[INJ_OPC_FLIP] ? (opcode ^ OPC_FLIP_MASK) : opcode;
  assign cin_exec  = carry_in | inj_ctl[INJ_CIN_STUCK];
  assign res_final = res_raw ^ {{(WIDTH-1){1'b0}}, inj_ctl[INJ_RES_FLIP]};
  assign vec_pred  = vec_raw ^ {{(WIDTH-1){1'b0}}, inj_ctl[INJ_VEC_FLIP]};

  balu_datapath #(.WIDTH(WIDTH)) u_datapath (
    .a         (op_a),
    .b         (op_b),
    .cin       (cin_exec),
    .op        (op_exec),
    .res       (res_raw),
    .carry_vec (vec_raw)
  );

  balu_predictor #(.WIDTH(WIDTH)) u_predictor (
    .op        (opcode),
    .a         (op_a),
    .b         (op_b),
    .code_a    (code_a),
    .code_b    (code_b),
    .cin       (carry_in),
    .carry_vec (vec_pred),
    .pred      (pred_code)
  );

  balu_zero_count #(.W(WIDTH)) u_actual (
    .vec   (res_final),
    .zeros (actual_code)
  );

  assign pred_in_range = (pred_code >= 0) && (pred_code <= N_S);
  assign mismatch      = !pred_in_range || (pred_code[CODE_W-1:0] != actual_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result      <= '0;
      result_code <= CODE_W'(WIDTH);
      fault_flag  <= 1'b0;
    end else begin
      result      <= res_final;
      result_code <= pred_code[CODE_W-1:0];
      fault_flag  <= mismatch;
    end
  end

  // R1: addition result one edge later
  assert_add_value_R1 : assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == OP_ADD && inj_ctl == '0) |=>
      result == ($past(op_a) + $past(op_b) + {{(WIDTH-1){1'b0}}, $past(carry_in)}));

  // R3: inversion of operand A
  assert_not_value_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == OP_NOT && inj_ctl == '0) |=> result == ~$past(op_a));

  // R5: no alarm on clean operation
  assert_no_false_alarm_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    (inj_ctl == '0) |=> !fault_flag);

  // R6: stuck carry on an add without carry is caught
  assert_stuck_cin_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    (inj_ctl == 4'b0001 && opcode == OP_ADD && !carry_in) |=> fault_flag);

  // R7: a corrupted result bit is caught
  assert_result_flip_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    (inj_ctl == 4'b0010) |=> fault_flag);

  // R10: undefined opcodes give an all-zero result with code n
  assert_undefined_op_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    (inj_ctl == '0 && (opcode == 6'h00 || opcode > 6'h07)) |=>
      (result == '0 && result_code == CODE_W'(WIDTH)));

endmodule

// File: tb/berger_checked_alu_tb_top.sv
`timescale 1ns/1ps
module berger_checked_alu_tb_top;

  localparam int W = 32;
  localparam int K = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst_n;
  logic [W-1:0] a, b;
  logic [K-1:0] ca, cb;
  logic         cin;
  logic [5:0]   op;
  logic [3:0]   inj;
  wire  [W-1:0] res;
  wire  [K-1:0] code;
  wire          flt;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] prev_res = '0;

  berger_checked_alu #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_a(a), .op_b(b), .code_a(ca), .code_b(cb),
    .carry_in(cin), .opcode(op), .inj_ctl(inj),
    .result(res), .result_code(code), .fault_flag(flt)
  );

  function automatic int zc(input logic [W-1:0] v);
    return W - $countones(v);
  endfunction

  // behavioural reference of the requirements
  function automatic logic [W-1:0] model(input logic [5:0] o, input logic [W-1:0] x,
                                         input logic [W-1:0] y, input logic c,
                                         input logic [3:0] i);
    logic [5:0]   eo;
    logic [W-1:0] ec, r;
    eo = i[3] ? (o ^ 6'h06) : o;
    ec = {{(W-1){1'b0}}, (c | i[0])};
    case (eo)
      6'h01:   r = x + y + ec;
      6'h02:   r = x - y - ec;
      6'h03:   r = x | y;
      6'h04:   r = x & y;
      6'h05:   r = ~(x ^ y);
      6'h06:   r = x ^ y;
      6'h07:   r = ~x;
      default: r = '0;
    endcase
    if (i[1]) r[0] = ~r[0];
    return r;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // exp_fault: -1 means the flag is not checked
  task automatic run(input string tag, input logic [5:0] o, input logic [W-1:0] x,
                     input logic [W-1:0] y, input logic c, input logic [3:0] i,
                     input int exp_fault, input bit chk_code);
    logic [W-1:0] er;
    @(negedge clk);
    op = o; a = x; b = y; cin = c; inj = i;
    ca = K'(zc(x)); cb = K'(zc(y));
    #2 check("R12", "held result", res, prev_res);
    er = model(o, x, y, c, i);
    @(negedge clk);
    check(tag, "result", res, er);
    if (chk_code)
      check(tag, "code", W'(code), W'(zc(model(o, x, y, c, i & 4'b1101))));
    if (exp_fault >= 0)
      check(tag, "fault", W'(flt), W'(exp_fault));
    prev_res = er;
  endtask

  function automatic logic [W-1:0] pattern(input int sel);
    case (sel)
      0:       return '0;
      1:       return '1;
      2:       return {{(W-1){1'b0}}, 1'b1} << $urandom_range(W-1);
      3:       return ~({{(W-1){1'b0}}, 1'b1} << $urandom_range(W-1));
      default: return $urandom;
    endcase
  endfunction

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; a = '0; b = '0; ca = '0; cb = '0; cin = 1'b0; op = '0; inj = '0;
    repeat (3) @(negedge clk);
    check("R11", "reset result", res, '0);
    check("R11", "reset code", W'(code), W);
    check("R11", "reset fault", W'(flt), '0);
    rst_n = 1'b1;

    // R1 addition
    run("R1", 6'h01, 32'd1, 32'd2, 1'b0, 4'h0, 0, 1);
    run("R1", 6'h01, 32'hFFFFFFFF, 32'd0, 1'b1, 4'h0, 0, 1);
    run("R1", 6'h01, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 4'h0, 0, 1);
    // R2 subtraction
    run("R2", 6'h02, 32'd5, 32'd3, 1'b0, 4'h0, 0, 1);
    run("R2", 6'h02, 32'd0, 32'd1, 1'b0, 4'h0, 0, 1);
    run("R2", 6'h02, 32'd7, 32'd7, 1'b1, 4'h0, 0, 1);
    // R3 logic operations
    run("R3", 6'h03, 32'd4, 32'd5, 1'b0, 4'h0, 0, 1);
    run("R3", 6'h04, 32'hF0F0_1234, 32'h0FF0_FFFF, 1'b0, 4'h0, 0, 1);
    run("R3", 6'h05, 32'd4, 32'd5, 1'b0, 4'h0, 0, 1);
    run("R3", 6'h06, 32'hAAAA_5555, 32'hFFFF_0000, 1'b0, 4'h0, 0, 1);
    run("R3", 6'h07, 32'h0000_00FF, 32'd0, 1'b0, 4'h0, 0, 1);

    // R4 and R5: clean random and extreme operations
    for (int n = 0; n < 2500; n++) begin
      run("R4 R5", 6'(1 + $urandom_range(6)), pattern($urandom_range(5)),
          pattern($urandom_range(5)), 1'($urandom_range(1)), 4'h0, 0, 1);
    end

    // R6 stuck carry
    run("R6", 6'h01, 32'd1, 32'd2, 1'b0, 4'h1, 1, 0);
    run("R6", 6'h01, 32'd1, 32'd2, 1'b1, 4'h1, 0, 1);

    // R7 result bit flip
    for (int n = 0; n < 200; n++) begin
      run("R7", 6'(1 + $urandom_range(6)), $urandom, $urandom,
          1'($urandom_range(1)), 4'h2, 1, 1);
    end

    // R8 carry-vector flip
    for (int n = 0; n < 200; n++) begin
      run("R8", 6'(1 + $urandom_range(1)), $urandom, $urandom,
          1'($urandom_range(1)), 4'h4, 1, 0);
      run("R8", 6'(3 + $urandom_range(4)), $urandom, $urandom,
          1'($urandom_range(1)), 4'h4, 0, 1);
    end

    // R9 opcode corruption on the execution path
    run("R9", 6'h03, 32'd4, 32'd5, 1'b0, 4'h8, 1, 0);
    check("R9", "xnor value", prev_res, 32'hFFFFFFFE);

    // R10 undefined opcodes
    run("R10", 6'h00, 32'h1234_5678, 32'h9ABC_DEF0, 1'b1, 4'h0, 0, 1);
    run("R10", 6'h08, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 4'h0, 0, 1);
    run("R10", 6'h3F, 32'hDEAD_BEEF, 32'h0, 1'b1, 4'h0, 0, 1);

    summary();
    $finish;
  end

endmodule